// File: doc/BRIEF.md
# ATA Task-File Command Issuer

This block turns a single block-transfer request into the ordered series of register accesses that starts an ATA command. A request carries a direction (read or write), a transfer mode (programmed I/O or DMA), a 48-bit logical block address, a 16-bit sector count and a device number (0 or 1). The block drives a small register-bus master port with a request/acknowledge handshake, a 4-bit register address and 8-bit data in each direction.

For each request the block waits until the status register shows the device not busy. It then reads the device register and writes a new value that selects the wanted device. If that write moves the device-select bit, the block waits a settle time and polls for not-busy again. After that it writes the task-file registers and, last of all, the command opcode. The short 28-bit command form is used when it can address the request. Otherwise the block uses the extended 48-bit form, which writes every register twice: the high-order bytes first, then the low-order bytes. A one-cycle `done` pulse marks that the command byte has been written. If the device stays busy for too long, the block stops with a one-cycle `err` pulse and a code that says which wait timed out.

The data phase, any DMA engine, interrupts and the electrical bus timing belong to other blocks.

Top module: `ata_cmd_issuer`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err` and `bus_req` are all low, and `bus_req` is never high while `busy` is low.
- R2: The extended form is chosen when the sector count is 256 or more, or when LBA plus count is 2^28 or more. Otherwise the 28-bit form is used. At the boundaries this means count 255 stays short, and LBA+count equal to 2^28-1 stays short.
- R3: In the extended form the writes after device selection are: address 1 ← 0x00, address 2 ← count[15:8], address 3 ← LBA[31:24], address 4 ← LBA[39:32], address 5 ← LBA[47:40]. These are followed by address 1 ← 0x00, address 2 ← count[7:0], address 3 ← LBA[7:0], address 4 ← LBA[15:8], address 5 ← LBA[23:16]. The 28-bit form writes only the second group of five.
- R4: The device-register value (address 6) is 0xE0 | dev<<4 | LBA[27:24] in the 28-bit form, and 0xE0 | dev<<4 in the extended form. Bit 6 is the LBA-mode bit.
- R5: Before touching the device register, the block reads the status register (address 7) until bit 7 (busy) reads 0.
- R6: Device selection reads address 6 once and then writes address 6, with bit 4 equal to the requested device number.
- R7: When bit 4 of the old device-register value differs from the requested device, the block waits at least SETTLE_CYCLES cycles after the device write. It then polls status until not-busy before the first task-file write. When bit 4 does not differ, no status read happens between the device write and the task-file writes.
- R8: The command register (address 7) is written last. `done` is high for exactly one cycle, in the cycle after the command write is acknowledged.
- R9: The opcodes are: 28-bit PIO read 0x20, PIO write 0x30, DMA read 0xC8, DMA write 0xCA. The extended ones are PIO read 0x24, PIO write 0x34, DMA read 0x25, DMA write 0x35, and all four equal 0x24 once bits 0 and 4 are masked.
- R10: A status poll that still reads busy when TIMEOUT_CYCLES have passed in that poll ends the request. `err` pulses for one cycle with `err_code` 1 for the poll before selection, or 2 for the poll after the settle wait. No command write is issued.
- R11: A `start` pulse while `busy` is high is ignored and does not change the request in progress.
- R12: Once `bus_req` is raised, it stays high with `bus_we`, `bus_addr` and `bus_wdata` unchanged until the cycle `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that accepts the request fields when the block is idle |
| rq_write | input | 1 | 1 = write to the device, 0 = read |
| rq_dma | input | 1 | 1 = DMA opcode, 0 = PIO opcode |
| rq_lba | input | 48 | Starting logical block address |
| rq_count | input | 16 | Sector count |
| rq_dev | input | 1 | Target device number |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse after the command byte write is acknowledged |
| err | output | 1 | One-cycle pulse when a busy wait times out |
| err_code | output | 2 | 1 = timeout before selection, 2 = timeout after device change; held until the next start |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 4 | Task-file register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete; read data valid in this cycle |
| bus_rdata | input | 8 | Read data |

## Verification
The assertions assume that the register bus raises `bus_ack` only while `bus_req` is pending, and for a single cycle, with `bus_rdata` valid in that cycle. The bench's register responder raises the acknowledge one cycle after it sees a request and drops it the next cycle, so the master always sees the required pattern. The bench also pulses `start` for one cycle at a time. The only extra pulse it sends while a request is running is the one that checks that such a pulse is ignored.

// File: rtl/ata_iss_pkg.sv
package ata_iss_pkg;

    // Task-file register addresses
    localparam logic [3:0] TF_FEAT = 4'd1;
    localparam logic [3:0] TF_CNT  = 4'd2;
    localparam logic [3:0] TF_LBA0 = 4'd3;
    localparam logic [3:0] TF_LBA1 = 4'd4;
    localparam logic [3:0] TF_LBA2 = 4'd5;
    localparam logic [3:0] TF_DEV  = 4'd6;
    localparam logic [3:0] TF_CMD  = 4'd7;
    localparam logic [3:0] TF_STAT = 4'd7;

    // Opcodes
    localparam logic [7:0] OP_PIO_RD    = 8'h20;
    localparam logic [7:0] OP_PIO_WR    = 8'h30;
    localparam logic [7:0] OP_DMA_RD    = 8'hC8;
    localparam logic [7:0] OP_DMA_WR    = 8'hCA;
    localparam logic [7:0] OP_PIO_RD_X  = 8'h24;
    localparam logic [7:0] OP_PIO_WR_X  = 8'h34;
    localparam logic [7:0] OP_DMA_RD_X  = 8'h25;
    localparam logic [7:0] OP_DMA_WR_X  = 8'h35;

    localparam logic [7:0] DEV_BASE     = 8'hE0;

    // Error codes
    localparam logic [1:0] ERR_NONE     = 2'd0;
    localparam logic [1:0] ERR_TO_SEL   = 2'd1;
    localparam logic [1:0] ERR_TO_SETTLE = 2'd2;

    // Task-file step indices: 0..4 high bytes, 5..9 low bytes, 10 command
    localparam logic [3:0] STEP_LO   = 4'd5;
    localparam logic [3:0] STEP_LAST = 4'd10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POLL_SEL,
        S_RD_DEV,
        S_WR_DEV,
        S_SETTLE,
        S_POLL_SET,
        S_TASK
    } iss_state_t;

    typedef struct packed {
        logic        wr;
        logic        dma;
        logic [47:0] lba;
        logic [15:0] cnt;
        logic        dev;
    } iss_req_t;

endpackage

// File: rtl/ata_iss_form.sv
module ata_iss_form
    import ata_iss_pkg::*;
#(
    parameter int SHORT_LBA_W = 28
) (
    input  iss_req_t    rq,
    input  logic [3:0]  step,
    output logic        is_ext,
    output logic [7:0]  dev_byte,
    output logic [3:0]  tf_addr,
    output logic [7:0]  tf_data
);
    localparam int SUM_W = 49;

    logic [SUM_W-1:0] end_sum;
    logic [7:0]       opcode;

    always_comb begin
        end_sum = {1'b0, rq.lba} + {{(SUM_W-16){1'b0}}, rq.cnt};
        is_ext  = (rq.cnt[15:8] != 8'd0) || (|end_sum[SUM_W-1:SHORT_LBA_W]);

        unique case ({is_ext, rq.dma, rq.wr})
            3'b000:  opcode = OP_PIO_RD;
            3'b001:  opcode = OP_PIO_WR;
            3'b010:  opcode = OP_DMA_RD;
            3'b011:  opcode = OP_DMA_WR;
            3'b100:  opcode = OP_PIO_RD_X;
            3'b101:  opcode = OP_PIO_WR_X;
            3'b110:  opcode = OP_DMA_RD_X;
            default: opcode = OP_DMA_WR_X;
        endcase

        dev_byte = DEV_BASE | {3'b000, rq.dev, 4'b0000}
                 | (is_ext ? 8'h00 : {4'h0, rq.lba[27:24]});

        unique case (step)
            4'd0:    begin tf_addr = TF_FEAT; tf_data = 8'h00;          end
            4'd1:    begin tf_addr = TF_CNT;  tf_data = rq.cnt[15:8];   end
            4'd2:    begin tf_addr = TF_LBA0; tf_data = rq.lba[31:24];  end
            4'd3:    begin tf_addr = TF_LBA1; tf_data = rq.lba[39:32];  end
            4'd4:    begin tf_addr = TF_LBA2; tf_data = rq.lba[47:40];  end
            4'd5:    begin tf_addr = TF_FEAT; tf_data = 8'h00;          end
            4'd6:    begin tf_addr = TF_CNT;  tf_data = rq.cnt[7:0];    end
            4'd7:    begin tf_addr = TF_LBA0; tf_data = rq.lba[7:0];    end
            4'd8:    begin tf_addr = TF_LBA1; tf_data = rq.lba[15:8];   end
            4'd9:    begin tf_addr = TF_LBA2; tf_data = rq.lba[23:16];  end
            default: begin tf_addr = TF_CMD;  tf_data = opcode;         end
        endcase
    end

endmodule

// File: rtl/ata_iss_seq.sv
module ata_iss_seq
    import ata_iss_pkg::*;
#(
    parameter int SETTLE_CYCLES  = 80,
    parameter int TIMEOUT_CYCLES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  iss_req_t    start_rq,
    output iss_req_t    cur_rq,
    output logic [3:0]  cur_step,
    input  logic        is_ext,
    input  logic [7:0]  dev_byte,
    input  logic [3:0]  tf_addr,
    input  logic [7:0]  tf_data,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [1:0]  err_code,
    output logic        bus_req,
    output logic        bus_we,
    output logic [3:0]  bus_addr,
    output logic [7:0]  bus_wdata,
    input  logic        bus_ack,
    input  logic [7:0]  bus_rdata
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam int CW = (TW > SW) ? TW : SW;
    localparam logic [CW-1:0] TO_LIM  = CW'(TIMEOUT_CYCLES);
    localparam logic [CW-1:0] SET_LIM = CW'(SETTLE_CYCLES - 1);

    typedef struct packed {
        iss_state_t   st;
        iss_req_t     rq;
        logic [3:0]   step;
        logic [CW-1:0] cnt;
        logic         tog;
        logic         req;
        logic         we;
        logic [3:0]   addr;
        logic [7:0]   wdata;
        logic         done;
        logic         err;
        logic [1:0]   code;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.rq   = start_rq;
                    d.st   = S_POLL_SEL;
                    d.cnt  = '0;
                    d.code = ERR_NONE;
                end
            end
            S_POLL_SEL, S_POLL_SET: begin
                if (q.cnt != TO_LIM) d.cnt = q.cnt + 1'b1;
                if (!q.req) begin
                    d.req  = 1'b1;
                    d.we   = 1'b0;
                    d.addr = TF_STAT;
                end else if (bus_ack) begin
                    d.req = 1'b0;
                    if (!bus_rdata[7]) begin
                        if (q.st == S_POLL_SEL) begin
                            d.st = S_RD_DEV;
                        end else begin
                            d.st   = S_TASK;
                            d.step = is_ext ? 4'd0 : STEP_LO;
                        end
                    end else if (q.cnt >= TO_LIM) begin
                        d.err  = 1'b1;
                        d.code = (q.st == S_POLL_SEL) ? ERR_TO_SEL : ERR_TO_SETTLE;
                        d.st   = S_IDLE;
                    end
                end
            end
            S_RD_DEV: begin
                if (!q.req) begin
                    d.req  = 1'b1;
                    d.we   = 1'b0;
                    d.addr = TF_DEV;
                end else if (bus_ack) begin
                    d.req = 1'b0;
                    d.tog = bus_rdata[4] ^ q.rq.dev;
                    d.st  = S_WR_DEV;
                end
            end
            S_WR_DEV: begin
                if (!q.req) begin
                    d.req   = 1'b1;
                    d.we    = 1'b1;
                    d.addr  = TF_DEV;
                    d.wdata = dev_byte;
                end else if (bus_ack) begin
                    d.req = 1'b0;
                    d.cnt = '0;
                    if (q.tog) begin
                        d.st = S_SETTLE;
                    end else begin
                        d.st   = S_TASK;
                        d.step = is_ext ? 4'd0 : STEP_LO;
                    end
                end
            end
            S_SETTLE: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt >= SET_LIM) begin
                    d.st  = S_POLL_SET;
                    d.cnt = '0;
                end
            end
            S_TASK: begin
                if (!q.req) begin
                    d.req   = 1'b1;
                    d.we    = 1'b1;
                    d.addr  = tf_addr;
                    d.wdata = tf_data;
                end else if (bus_ack) begin
                    d.req = 1'b0;
                    if (q.step == STEP_LAST) begin
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end else begin
                        d.step = q.step + 4'd1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cur_rq    = q.rq;
    assign cur_step  = q.step;
    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign err_code  = q.code;
    assign bus_req   = q.req;
    assign bus_we    = q.we;
    assign bus_addr  = q.addr;
    assign bus_wdata = q.wdata;

    assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    assert_done_after_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_req && bus_ack && bus_we && bus_addr == TF_CMD));

    assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_err_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != ERR_NONE) && !busy);

    assert_dev_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == TF_DEV) |-> (bus_wdata[4] == q.rq.dev));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

endmodule

// File: rtl/ata_cmd_issuer.sv
module ata_cmd_issuer
    import ata_iss_pkg::*;
#(
    parameter int SETTLE_CYCLES  = 80,
    parameter int TIMEOUT_CYCLES = 4096,
    parameter int SHORT_LBA_W    = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rq_write,
    input  logic        rq_dma,
    input  logic [47:0] rq_lba,
    input  logic [15:0] rq_count,
    input  logic        rq_dev,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [1:0]  err_code,
    output logic        bus_req,
    output logic        bus_we,
    output logic [3:0]  bus_addr,
    output logic [7:0]  bus_wdata,
    input  logic        bus_ack,
    input  logic [7:0]  bus_rdata
);
    iss_req_t   start_rq, cur_rq;
    logic [3:0] cur_step;
    logic       is_ext;
    logic [7:0] dev_byte;
    logic [3:0] tf_addr;
    logic [7:0] tf_data;

    assign start_rq = '{wr: rq_write, dma: rq_dma, lba: rq_lba, cnt: rq_count, dev: rq_dev};

    ata_iss_form #(
        .SHORT_LBA_W (SHORT_LBA_W)
    ) u_form (
        .rq       (cur_rq),
        .step     (cur_step),
        .is_ext   (is_ext),
        .dev_byte (dev_byte),
        .tf_addr  (tf_addr),
        .tf_data  (tf_data)
    );

    ata_iss_seq #(
        .SETTLE_CYCLES  (SETTLE_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_rq  (start_rq),
        .cur_rq    (cur_rq),
        .cur_step  (cur_step),
        .is_ext    (is_ext),
        .dev_byte  (dev_byte),
        .tf_addr   (tf_addr),
        .tf_data   (tf_data),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .err_code  (err_code),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: tb/sim_ata_cmd_issuer.sv
`timescale 1ns/1ps
module sim_ata_cmd_issuer;
    localparam int SETTLE  = 20;
    localparam int TIMEOUT = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rq_write = 1'b0, rq_dma = 1'b0, rq_dev = 1'b0;
    logic [47:0] rq_lba = '0;
    logic [15:0] rq_count = '0;
    logic        busy, done, err;
    logic [1:0]  err_code;
    logic        bus_req, bus_we;
    logic [3:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = '0;

    ata_cmd_issuer #(.SETTLE_CYCLES(SETTLE), .TIMEOUT_CYCLES(TIMEOUT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rq_write(rq_write), .rq_dma(rq_dma),
        .rq_lba(rq_lba), .rq_count(rq_count), .rq_dev(rq_dev), .busy(busy), .done(done),
        .err(err), .err_code(err_code), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural device model and transaction log
    logic [11:0] exp_q[$];
    logic [7:0]  dev_reg = 8'h00;
    int busy_left = 0, busy_post = 0;
    int stat_pre = 0, stat_post = 0, writes_seen = 0;
    bit seen_dev_rd = 0, seen_dev_wr = 0, cmd_seen = 0, gap_open = 0;
    int dev_wr_cyc = 0, gap = 0, cmd_cyc = 0;
    int done_cnt = 0, err_cnt = 0, done_cyc = 0;
    logic [1:0] err_code_seen = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(!(done && err), "R10 done/err exclusive", {done, err}, 0);
                if (!busy) chk(!bus_req, "R1 no request while idle", bus_req, 0);
            end
            if (done) begin done_cnt++; done_cyc = cyc; end
            if (err) begin err_cnt++; err_code_seen = err_code; end
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                bus_ack = 1'b1;
                if (gap_open) begin gap = cyc - dev_wr_cyc; gap_open = 0; end
                if (bus_we) begin
                    writes_seen++;
                    if (exp_q.size() == 0) begin
                        chk(0, "R8 unexpected write", {bus_addr, bus_wdata}, 0);
                    end else begin
                        logic [11:0] e;
                        e = exp_q.pop_front();
                        chk({bus_addr, bus_wdata} == e, "R3/R4/R9 write order and value",
                            {bus_addr, bus_wdata}, e);
                    end
                    if (bus_addr == 4'd6) begin
                        dev_reg = bus_wdata; seen_dev_wr = 1; dev_wr_cyc = cyc;
                        gap_open = 1; busy_left = busy_post;
                    end
                    if (bus_addr == 4'd7) begin cmd_seen = 1; cmd_cyc = cyc; end
                end else if (bus_addr == 4'd6) begin
                    seen_dev_rd = 1; bus_rdata = dev_reg;
                end else begin
                    if (seen_dev_wr) stat_post++; else if (!seen_dev_rd) stat_pre++;
                    if (busy_left > 0) begin bus_rdata = 8'hD0; busy_left--; end
                    else bus_rdata = 8'h50;
                end
            end
        end
    end

    task automatic run_req(input bit wr, input bit dma, input longint lba, input int cnt,
                           input bit dev, input int bpre, input int bpost,
                           input int exp_err, input bit inject);
        bit ext, tog;
        logic [7:0] op, devb;
        longint s;
        int d0, e0, w0;
        s   = lba + cnt;
        ext = (cnt >= 256) || (s >= 64'h1000_0000);
        if (ext) op = dma ? (wr ? 8'h35 : 8'h25) : (wr ? 8'h34 : 8'h24);
        else     op = dma ? (wr ? 8'hCA : 8'hC8) : (wr ? 8'h30 : 8'h20);
        devb = 8'hE0 | (dev ? 8'h10 : 8'h00) | (ext ? 8'h00 : {4'h0, lba[27:24]});
        tog  = dev_reg[4] != dev;
        exp_q.delete();
        exp_q.push_back({4'd6, devb});
        if (ext) begin
            exp_q.push_back({4'd1, 8'h00});
            exp_q.push_back({4'd2, 8'(cnt >> 8)});
            exp_q.push_back({4'd3, 8'(lba >> 24)});
            exp_q.push_back({4'd4, 8'(lba >> 32)});
            exp_q.push_back({4'd5, 8'(lba >> 40)});
        end
        exp_q.push_back({4'd1, 8'h00});
        exp_q.push_back({4'd2, 8'(cnt)});
        exp_q.push_back({4'd3, 8'(lba)});
        exp_q.push_back({4'd4, 8'(lba >> 8)});
        exp_q.push_back({4'd5, 8'(lba >> 16)});
        exp_q.push_back({4'd7, op});
        if (exp_err == 1) exp_q.delete();
        if (exp_err == 2) begin exp_q.delete(); exp_q.push_back({4'd6, devb}); end
        busy_left = bpre; busy_post = bpost;
        stat_pre = 0; stat_post = 0; seen_dev_rd = 0; seen_dev_wr = 0; cmd_seen = 0;
        gap = 0; gap_open = 0;
        d0 = done_cnt; e0 = err_cnt; w0 = writes_seen;
        @(negedge clk);
        start = 1; rq_write = wr; rq_dma = dma; rq_lba = lba[47:0]; rq_count = cnt[15:0]; rq_dev = dev;
        @(negedge clk);
        start = 0;
        if (inject) begin
            repeat (6) @(negedge clk);
            start = 1; rq_write = !wr; rq_dma = !dma; rq_lba = 48'h0; rq_count = 16'd1; rq_dev = !dev;
            @(negedge clk);
            start = 0;
        end
        for (int i = 0; i < 5000; i++) begin
            if (done_cnt != d0 || err_cnt != e0) break;
            @(negedge clk);
        end
        repeat (30) @(negedge clk);
        if (exp_err == 0) begin
            chk(done_cnt == d0 + 1, "R8 one done pulse", done_cnt - d0, 1);
            chk(cmd_seen && done_cyc == cmd_cyc + 1, "R8 done one cycle after command ack",
                done_cyc - cmd_cyc, 1);
            chk(exp_q.size() == 0, ext ? "R2/R3 all writes issued (ext)" : "R2 all writes issued (short)",
                exp_q.size(), 0);
            chk(stat_pre == bpre + 1, "R5 polls before select", stat_pre, bpre + 1);
            if (tog) begin
                chk(stat_post == bpost + 1, "R7 re-poll after device change", stat_post, bpost + 1);
                chk(gap >= SETTLE, "R7 settle gap", gap, SETTLE);
            end else begin
                chk(stat_post == 0, "R7 no re-poll without change", stat_post, 0);
            end
            if (inject) chk(writes_seen - w0 == (ext ? 12 : 7), "R11 start while busy ignored",
                            writes_seen - w0, ext ? 12 : 7);
        end else begin
            chk(err_cnt == e0 + 1, "R10 one err pulse", err_cnt - e0, 1);
            chk(err_code_seen == 2'(exp_err), "R10 err code", err_code_seen, exp_err);
            chk(!cmd_seen && done_cnt == d0, "R10 no command after timeout", cmd_seen, 0);
            chk(writes_seen - w0 == (exp_err == 2 ? 1 : 0), "R10 write count", writes_seen - w0,
                exp_err == 2 ? 1 : 0);
            busy_left = 0; busy_post = 0;
        end
        chk(!busy && !bus_req, "R1 idle after request", {busy, bus_req}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired R8 actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy && !done && !err && !bus_req, "R1 reset state", {busy, done, err, bus_req}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!busy && !bus_req, "R1 idle after reset release", {busy, bus_req}, 0);
        // short PIO read, no device change (R2 R3 R4 R5 R9)
        run_req(0, 0, 48'h0123456, 8, 0, 3, 0, 0, 0);
        // short DMA write to device 1: device change (R6 R7)
        run_req(1, 1, 48'h0ABCDEF, 16, 1, 0, 2, 0, 0);
        // count 256 forces extended, PIO write (R2 R3)
        run_req(1, 0, 48'h000100, 256, 1, 1, 0, 0, 0);
        // count 255 stays short (R2 boundary)
        run_req(0, 0, 48'h0000200, 255, 1, 0, 0, 0, 0);
        // lba+count = 2^28-1 stays short; = 2^28 goes extended (R2 boundary)
        run_req(0, 1, 64'h0FFF_FFFB, 4, 1, 0, 0, 0, 0);
        run_req(0, 1, 64'h0FFF_FFFC, 4, 1, 0, 0, 0, 0);
        // large 48-bit address, DMA write, device change back to 0
        run_req(1, 1, 48'hA5B4_C3D2_E1F0, 3, 0, 2, 1, 0, 0);
        // start pulse while busy ignored (R11)
        run_req(0, 0, 48'h0345678, 2, 0, 0, 0, 0, 1);
        // timeout before selection (R10 code 1)
        run_req(0, 0, 48'h10, 1, 0, 1000000, 0, 1, 0);
        // timeout after device change (R10 code 2)
        run_req(0, 0, 48'h10, 1, 1, 0, 1000000, 2, 0);
        // recovery after errors
        run_req(1, 0, 48'h0000042, 1, 1, 0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule